// File: doc/BRIEF.md
# Lane Alignment Sequence Transmitter

This block sits on the transmit side of a serial converter link, just ahead of the line encoder. Each clock it produces one octet and a flag that marks the octet as a control character. While the receiver holds its active-low synchronisation request low, the block sends comma characters (K28.5). When the request is released, the block waits for the next wrap of its local multiframe counter. It then sends a fixed alignment pattern of four multiframes placed back to back. After that it passes user octets through.

The local multiframe counter runs freely from reset. Its period is the octets per frame times the frames per multiframe. Both link parameters arrive in minus-one form. The second alignment multiframe carries a marker character followed by fourteen configuration octets, taken from a packed input vector. Every alignment position that holds no start, end, marker or configuration octet carries a filler byte. The block also drives a scrambler bypass indication, which stays high for everything except user data.

The link parameters are static between resets. Their product must be at least seventeen, so that the configuration octets fit ahead of the end character.

Top module: `laneAlignTx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the output is 0xBC with the control flag and the bypass flag set. The local counter starts at position 0.
- R2: The local multiframe counter steps by one each clock from 0 up to (F+1)*(K+1)-1 and then wraps to 0. F and K are the minus-one encoded inputs `frameOctM1` and `framesM1`. The last position of every alignment multiframe carries /A/ (0x7C, control).
- R3: In the comma phase the output is 0xBC with the control flag set.
- R4: The alignment sequence begins in the cycle after a clock edge that samples `syncN` high while the counter is at its last position. That cycle is position 0 and carries /R/ (0x1C, control).
- R5: The alignment sequence lasts exactly four multiframes. In the cycle after the fourth /A/, the output becomes user data.
- R6: Multiframes 1, 3 and 4 carry /R/ at position 0 and /A/ at the last position. All positions in between hold filler.
- R7: Multiframe 2 carries /R/ at position 0 and /Q/ (0x9C, control) at position 1. Positions 2 to 15 carry configuration octet i = position-2, taken from `cfgOctets[8i+7:8i]` with the control flag clear.
- R8: A filler octet equals the low 8 bits of the counter position, so the ramp restarts with each multiframe. Its control flag is clear.
- R9: The bypass flag is high in the comma and alignment phases and low in the user phase. In the user phase the output equals `userData`, and the control flag equals `userCtrl`.
- R10: If a clock edge samples `syncN` low in any phase, the next cycle outputs 0xBC with the control flag set, and the sequence starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncN | input | 1 | Active-low synchronisation request from the receiver |
| frameOctM1 | input | 8 | Octets per frame minus one |
| framesM1 | input | 5 | Frames per multiframe minus one |
| cfgOctets | input | 112 | Fourteen configuration octets, octet i in bits 8i+7:8i |
| userData | input | 8 | User octet for the data phase |
| userCtrl | input | 1 | Control flag that goes with the user octet |
| txOctet | output | 8 | Octet to the line encoder |
| txIsCtrl | output | 1 | Octet is a control character |
| txScrBypass | output | 1 | Scrambler must pass this octet unchanged |

## Verification
The bench runs three multiframe lengths (18, 32 and 18 positions, with different F/K splits). Under each, the sync request is released at an arbitrary counter position and also exactly at the last position. The arbitrary release tests whether the start waits for the wrap. The release at the last position tests the boundary with no wait at all. Sync drops in the middle of the alignment sequence and for a single cycle during user data, which separates a clean restart from a sequencer that resumes where it stopped. Random user octets and control flags show that the data phase passes both fields through and that alignment characters never leak into it.

// File: rtl/laneAlignPkg.sv
package laneAlignPkg;
  localparam logic [7:0] CHAR_COMMA = 8'hBC;
  localparam logic [7:0] CHAR_START = 8'h1C;
  localparam logic [7:0] CHAR_END   = 8'h7C;
  localparam logic [7:0] CHAR_MARK  = 8'h9C;

  typedef enum logic [1:0] {
    PH_COMMA = 2'd0,
    PH_ALIGN = 2'd1,
    PH_USER  = 2'd2
  } phase_t;

  // one-hot strobes from the sequencer to the octet path
  typedef struct packed {
    logic selComma;
    logic selStart;
    logic selEnd;
    logic selMark;
    logic selCfg;
    logic selFill;
    logic selUser;
  } pathSel_t;
endpackage

// File: rtl/laneAlignLmfc.sv
module laneAlignLmfc #(
  parameter int FW = 8,
  parameter int KW = 5,
  localparam int PW = FW + KW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [FW-1:0] frameOctM1,
  input  logic [KW-1:0] framesM1,
  output logic [PW-1:0] pos,
  output logic          atLast
);
  logic [PW:0]   fCnt, kCnt, prod;
  logic [PW-1:0] lastPos;

  // undo the minus-one encoding before multiplying
  always_comb begin
    fCnt    = (PW+1)'(frameOctM1) + (PW+1)'(1);
    kCnt    = (PW+1)'(framesM1) + (PW+1)'(1);
    prod    = fCnt * kCnt;
    lastPos = PW'(prod - (PW+1)'(1));
  end

  assign atLast = (pos >= lastPos);

  always_ff @(posedge clk) begin
    if (!rstN)       pos <= '0;
    else if (atLast) pos <= '0;
    else             pos <= pos + PW'(1);
  end
endmodule

// File: rtl/laneAlignCtrl.sv
module laneAlignCtrl
  import laneAlignPkg::*;
#(
  parameter int PW    = 13,
  parameter int CFG_N = 14,
  parameter int MF_N  = 4,
  localparam int MW   = (MF_N > 1) ? $clog2(MF_N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          syncN,
  input  logic [PW-1:0] pos,
  input  logic          atLast,
  output phase_t        phase,
  output logic [MW-1:0] mfIdx,
  output pathSel_t      sel
);
  localparam logic [MW-1:0] MF_LAST   = MW'(MF_N - 1);
  localparam logic [MW-1:0] MF_CFG    = MW'(1);
  localparam logic [PW-1:0] POS_MARK  = PW'(1);
  localparam logic [PW-1:0] CFG_FIRST = PW'(2);
  localparam logic [PW-1:0] CFG_END   = PW'(2 + CFG_N);

  always_ff @(posedge clk) begin
    if (!rstN || !syncN) begin
      phase <= PH_COMMA;
      mfIdx <= '0;
    end else begin
      unique case (phase)
        PH_COMMA: if (atLast) begin
          phase <= PH_ALIGN;
          mfIdx <= '0;
        end
        PH_ALIGN: if (atLast) begin
          if (mfIdx == MF_LAST) phase <= PH_USER;
          else                  mfIdx <= mfIdx + MW'(1);
        end
        default: phase <= PH_USER;
      endcase
    end
  end

  logic inCfgMf;
  assign inCfgMf = (mfIdx == MF_CFG);

  always_comb begin
    sel = '0;
    unique case (phase)
      PH_COMMA: sel.selComma = 1'b1;
      PH_ALIGN: begin
        if (pos == '0)                                       sel.selStart = 1'b1;
        else if (atLast)                                     sel.selEnd   = 1'b1;
        else if (inCfgMf && pos == POS_MARK)                 sel.selMark  = 1'b1;
        else if (inCfgMf && pos >= CFG_FIRST && pos < CFG_END) sel.selCfg = 1'b1;
        else                                                 sel.selFill  = 1'b1;
      end
      default: sel.selUser = 1'b1;
    endcase
  end
endmodule

// File: rtl/laneAlignPath.sv
module laneAlignPath
  import laneAlignPkg::*;
#(
  parameter int PW    = 13,
  parameter int OW    = 8,
  parameter int CFG_N = 14
) (
  input  pathSel_t            sel,
  input  logic [PW-1:0]       pos,
  input  logic [CFG_N*OW-1:0] cfgOctets,
  input  logic [OW-1:0]       userData,
  input  logic                userCtrl,
  output logic [OW-1:0]       txOctet,
  output logic                txIsCtrl,
  output logic                txScrBypass
);
  localparam logic [PW-1:0] CFG_FIRST = PW'(2);

  logic [OW-1:0] cfgArr [CFG_N];
  logic [PW-1:0] cfgOff;
  logic [OW-1:0] cfgPick;

  for (genvar i = 0; i < CFG_N; i++) begin : gCfg
    assign cfgArr[i] = cfgOctets[i*OW +: OW];
  end

  assign cfgOff = pos - CFG_FIRST;

  always_comb begin
    cfgPick = '0;
    for (int i = 0; i < CFG_N; i++)
      if (cfgOff == PW'(i)) cfgPick = cfgArr[i];
  end

  always_comb begin
    txOctet  = CHAR_COMMA;
    txIsCtrl = 1'b1;
    if (sel.selStart)     txOctet = CHAR_START;
    else if (sel.selEnd)  txOctet = CHAR_END;
    else if (sel.selMark) txOctet = CHAR_MARK;
    else if (sel.selCfg) begin
      txOctet  = cfgPick;
      txIsCtrl = 1'b0;
    end else if (sel.selFill) begin
      txOctet  = pos[OW-1:0];
      txIsCtrl = 1'b0;
    end else if (sel.selUser) begin
      txOctet  = userData;
      txIsCtrl = userCtrl;
    end
    txScrBypass = !sel.selUser;
  end
endmodule

// File: rtl/laneAlignTx.sv
module laneAlignTx
  import laneAlignPkg::*;
#(
  parameter int FW    = 8,
  parameter int KW    = 5,
  parameter int OW    = 8,
  parameter int CFG_N = 14,
  parameter int MF_N  = 4,
  localparam int PW   = FW + KW,
  localparam int MW   = (MF_N > 1) ? $clog2(MF_N) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                syncN,
  input  logic [FW-1:0]       frameOctM1,
  input  logic [KW-1:0]       framesM1,
  input  logic [CFG_N*OW-1:0] cfgOctets,
  input  logic [OW-1:0]       userData,
  input  logic                userCtrl,
  output logic [OW-1:0]       txOctet,
  output logic                txIsCtrl,
  output logic                txScrBypass
);
  logic [PW-1:0] lmfcPos;
  logic          lmfcLast;
  phase_t        phase;
  logic [MW-1:0] mfIdx;
  pathSel_t      sel;

  laneAlignLmfc #(.FW(FW), .KW(KW)) i_lmfc (
    .clk(clk), .rstN(rstN), .frameOctM1(frameOctM1), .framesM1(framesM1),
    .pos(lmfcPos), .atLast(lmfcLast)
  );

  laneAlignCtrl #(.PW(PW), .CFG_N(CFG_N), .MF_N(MF_N)) i_ctrl (
    .clk(clk), .rstN(rstN), .syncN(syncN), .pos(lmfcPos), .atLast(lmfcLast),
    .phase(phase), .mfIdx(mfIdx), .sel(sel)
  );

  laneAlignPath #(.PW(PW), .OW(OW), .CFG_N(CFG_N)) i_path (
    .sel(sel), .pos(lmfcPos), .cfgOctets(cfgOctets), .userData(userData),
    .userCtrl(userCtrl), .txOctet(txOctet), .txIsCtrl(txIsCtrl),
    .txScrBypass(txScrBypass)
  );
endmodule

// File: rtl/laneAlignChecker.sv
module laneAlignChecker
  import laneAlignPkg::*;
#(
  parameter int PW = 13
) (
  input logic          clk,
  input logic          rstN,
  input logic          syncN,
  input logic [7:0]    txOctet,
  input logic          txIsCtrl,
  input logic          txScrBypass,
  input logic [PW-1:0] pos,
  input logic          atLast,
  input phase_t        phase
);
  assert_comma_on_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    !syncN |=> (txOctet == CHAR_COMMA && txIsCtrl && txScrBypass));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!syncN && phase != PH_COMMA) |=> (phase == PH_COMMA));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    atLast |=> (pos == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !atLast |=> (pos == $past(pos) + PW'(1)));

  assert_start_at_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phase == PH_ALIGN) |-> (pos == '0 && txOctet == CHAR_START && txIsCtrl));

  assert_end_char_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ALIGN && atLast) |-> (txOctet == CHAR_END && txIsCtrl));

  assert_handover_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phase == PH_USER) |-> ($past(txOctet) == CHAR_END && $past(atLast)));

  assert_user_bypass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_USER) |-> !txScrBypass);
endmodule

bind laneAlignTx laneAlignChecker #(.PW(PW)) i_chk (
  .clk(clk), .rstN(rstN), .syncN(syncN), .txOctet(txOctet), .txIsCtrl(txIsCtrl),
  .txScrBypass(txScrBypass), .pos(lmfcPos), .atLast(lmfcLast), .phase(phase)
);

// File: tb/test_laneAlignTx.sv
module test_laneAlignTx;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         syncN = 1'b0;
  logic [7:0]   frameOctM1 = 8'd1;
  logic [4:0]   framesM1 = 5'd8;
  logic [111:0] cfgOctets = '0;
  logic [7:0]   userData = 8'h00;
  logic         userCtrl = 1'b0;
  logic [7:0]   txOctet;
  logic         txIsCtrl;
  logic         txScrBypass;

  int nCmp = 0;
  int nBad = 0;
  // reference model state
  int mPos = 0, mPhase = 0, mMf = 0, mLast = 17;
  int mAbort = 0, mWrap = 0, mFirst = 1;

  always #4 clk = ~clk;

  laneAlignTx i_laneAlignTx (
    .clk(clk), .rstN(rstN), .syncN(syncN), .frameOctM1(frameOctM1),
    .framesM1(framesM1), .cfgOctets(cfgOctets), .userData(userData),
    .userCtrl(userCtrl), .txOctet(txOctet), .txIsCtrl(txIsCtrl),
    .txScrBypass(txScrBypass)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mPos = 0; mPhase = 0; mMf = 0; mAbort = 0; mFirst = 1;
    end else begin
      mWrap = (mPos >= mLast) ? 1 : 0;
      mAbort = 0;
      mFirst = 0;
      if (!syncN) begin
        if (mPhase != 0) mAbort = 1;
        mPhase = 0; mMf = 0;
      end else if (mPhase == 0 && mWrap == 1) begin
        mPhase = 1; mMf = 0;
      end else if (mPhase == 1 && mWrap == 1) begin
        if (mMf == 3) mPhase = 2;
        else mMf = mMf + 1;
      end
      mPos = (mWrap == 1) ? 0 : mPos + 1;
    end
  end

  task automatic compare();
    logic [7:0] eO;
    logic eC, eB;
    string tag;
    eB = 1'b1; eC = 1'b1; eO = 8'hBC; tag = "R3";
    if (!rstN || mFirst == 1) tag = "R1";
    else if (mPhase == 0) tag = (mAbort == 1) ? "R10" : "R3";
    else if (mPhase == 2) begin
      eO = userData; eC = userCtrl; eB = 1'b0; tag = "R5/R9";
    end else if (mPos == 0) begin
      eO = 8'h1C; tag = (mMf == 0) ? "R4" : "R6";
    end else if (mPos == mLast) begin
      eO = 8'h7C; tag = "R2/R6";
    end else if (mMf == 1 && mPos == 1) begin
      eO = 8'h9C; tag = "R7";
    end else if (mMf == 1 && mPos < 16) begin
      eO = cfgOctets[(mPos-2)*8 +: 8]; eC = 1'b0; tag = "R7";
    end else begin
      eO = 8'(mPos); eC = 1'b0; tag = "R8";
    end
    nCmp++;
    if (txOctet !== eO || txIsCtrl !== eC || txScrBypass !== eB) begin
      nBad++;
      $display("FAIL %s pos=%0d: got octet=%h ctrl=%b byp=%b expected octet=%h ctrl=%b byp=%b",
               tag, mPos, txOctet, txIsCtrl, txScrBypass, eO, eC, eB);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      userData = 8'($urandom);
      userCtrl = 1'($urandom % 4 == 0);
    end
  endtask

  task automatic newConfig(input int fM1, input int kM1, input int seed);
    rstN = 1'b0;
    syncN = 1'b0;
    frameOctM1 = 8'(fM1);
    framesM1 = 5'(kM1);
    mLast = (fM1 + 1) * (kM1 + 1) - 1;
    for (int i = 0; i < 14; i++) cfgOctets[i*8 +: 8] = 8'(seed + i * 37);
    step(4);              // R1 during reset
    rstN = 1'b1;
  endtask

  initial begin
    // config A: 18 positions, release at an arbitrary point
    newConfig(1, 8, 8'h51);
    step(23);
    syncN = 1'b1;
    step(18 * 5 + 20);
    // one-cycle drop during user data (R10)
    syncN = 1'b0; step(1);
    syncN = 1'b1; step(30);
    // drop in the middle of the configuration multiframe
    syncN = 1'b0; step(3);
    syncN = 1'b1;
    while (!(mPhase == 1 && mMf == 1 && mPos == 6)) step(1);
    syncN = 1'b0; step(5);
    syncN = 1'b1; step(130);

    // config B: 32 positions, release exactly at the last position
    newConfig(0, 31, 8'hC3);
    step(10);
    while (mPos != mLast) step(1);
    syncN = 1'b1;
    step(32 * 5 + 10);
    syncN = 1'b0; step(2);
    syncN = 1'b1; step(200);

    // config C: 18 positions with a different F/K split
    newConfig(2, 5, 8'h0E);
    step(7);
    syncN = 1'b1;
    step(18 * 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    nBad++;
    $display("FAIL watchdog: run did not end, got running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule